// File: doc/BRIEF.md
# SMBus Protocol Transaction Sequencer

This block sits between a byte-wide register front end and a bit-level bus engine. When the front end pulses a start request, the block latches the protocol code, the address byte, the command byte and the two data bytes. It then walks through a fixed list of primitive bus operations for that protocol. Each operation is handed to the bit engine over a request/acknowledge handshake, and the next operation is issued only after the current one has been acknowledged.

Bytes received from the target are stored in data0 or data1. When the list ends, the block reports one of three results:
- interrupt, for a completed transfer;
- busy plus byte-done, when a block transfer hands off to byte stepping;
- device error, for a refused transfer.

A target NACK or a bus failure on any operation except the final stop makes the block close the bus with a stop before it reports the error. Protocol codes that have no sequence are rejected at once, without any bus activity.

Top module: `smbus_xact_seq`

## Requirements
- R1: Operation codes on eng_op_o are 0 start (address byte on eng_wdata_o), 1 send byte, 2 receive byte with ACK, 3 receive last byte with NACK, 4 repeated start (address byte), and 5 stop. eng_req_o stays high, with op and wdata held stable, until eng_ack_i. After a start request the first operation is a start.
- R2: Protocol code 0 (quick) issues start with the address byte as given (bit 0 is R/W, 1 meaning read), then stop. The result is interrupt.
- R3: Code 1 (byte), write direction: start(address), send(command), stop. Read direction: start(address), receive-last, stop, with the byte stored in data0. The result is interrupt.
- R4: Code 2 (byte-data) sends the command after a write-direction start. It then either sends data0 and stops (write), or repeated-starts in read direction, receives the last byte into data0 and stops (read). The result is interrupt.
- R5: Code 3 (word). Write: start(W), send command, send data0, send data1, stop. Read: start(W), send command, repeated start(R), receive into data0 (low byte), receive-last into data1 (high byte), stop. The result is interrupt.
- R6: Code 5 (block header). Write: start(W), send command, send data0 as the count. Read: start(W), send command, repeated start(R), receive the count into data0. No stop is issued, and the result is busy plus byte-done.
- R7: Code 6 (I2C block read) ignores address bit 0. It issues start({addr[7:1],0}), send data1 as the offset, repeated start({addr[7:1],1}), then receive with ACK into data0. No stop is issued, and the result is busy plus byte-done.
- R8: A NACK on any operation other than stop is followed by a single stop. The result is then device error, and data0 and data1 keep their latched values.
- R9: Codes 4 and 7 issue no operation. done_o and device error appear in the cycle after the start request.
- R10: A start request while a transaction is in flight is ignored, and the running sequence continues unchanged.
- R11: After reset all outputs are low. Each transaction ends with a one-cycle done_o and exactly one of interrupt, byte-done or device error. A new start clears the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse |
| proto_i | input | 3 | Protocol code |
| addr_i | input | DATA_W | Target address in bits 7:1, R/W in bit 0 |
| cmd_i | input | DATA_W | Command byte |
| data0_i | input | DATA_W | Data byte 0 (low / count) |
| data1_i | input | DATA_W | Data byte 1 (high / offset) |
| eng_req_o | output | 1 | Operation request to bit engine |
| eng_op_o | output | 3 | Operation code |
| eng_wdata_o | output | DATA_W | Byte to transmit |
| eng_ack_i | input | 1 | Operation finished |
| eng_nack_i | input | 1 | Target NACK or bus failure, valid with ack |
| eng_rdata_i | input | DATA_W | Received byte, valid with ack |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| sts_busy_o | output | 1 | Host busy |
| sts_intr_o | output | 1 | Transfer completed |
| sts_byte_done_o | output | 1 | Byte ready for block stepping |
| sts_dev_err_o | output | 1 | Device error |
| data0_o | output | DATA_W | Data byte 0 |
| data1_o | output | DATA_W | Data byte 1 |

## Verification
The bench builds the block with the default DATA_W of 8, so every sequence works on whole bytes. The bench's engine model uses a two-cycle acknowledge latency. That latency leaves room for a second start request to land in the middle of a sequence. It also lets NACKs be injected on the address phase and on a later data phase, and lets the longest word-read list run to its final stop.

// File: rtl/smbus_xact_pkg.sv
package smbus_xact_pkg;
  localparam int MAX_STEPS = 6;
  localparam int STEP_W    = $clog2(MAX_STEPS);

  localparam logic [2:0] PROTO_QUICK = 3'd0;
  localparam logic [2:0] PROTO_BYTE  = 3'd1;
  localparam logic [2:0] PROTO_BDATA = 3'd2;
  localparam logic [2:0] PROTO_WORD  = 3'd3;
  localparam logic [2:0] PROTO_PCALL = 3'd4;
  localparam logic [2:0] PROTO_BLOCK = 3'd5;
  localparam logic [2:0] PROTO_I2CRD = 3'd6;

  typedef enum logic [2:0] {
    OP_START = 3'd0, OP_SEND = 3'd1, OP_RECV = 3'd2,
    OP_RECV_LAST = 3'd3, OP_RSTART = 3'd4, OP_STOP = 3'd5
  } bus_op_e;

  typedef enum logic [2:0] {
    WS_NONE, WS_ADDR_RAW, WS_ADDR_WR, WS_ADDR_RD, WS_CMD, WS_D0, WS_D1
  } wsel_e;

  typedef enum logic [1:0] {RS_NONE, RS_D0, RS_D1} rsel_e;

  typedef enum logic {RES_INTR, RES_BYTE_DONE} res_e;

  typedef struct packed {
    bus_op_e op;
    wsel_e   wsel;
    rsel_e   rsel;
    logic    last;
    res_e    res;
  } step_t;

  function automatic step_t mk(bus_op_e o, wsel_e w, rsel_e r, logic l, res_e s);
    step_t t;
    t.op = o; t.wsel = w; t.rsel = r; t.last = l; t.res = s;
    return t;
  endfunction

  function automatic logic proto_unsup(logic [2:0] p);
    return (p == PROTO_PCALL) || (p == 3'd7);
  endfunction
endpackage

// File: rtl/smbus_xact_decode.sv
module smbus_xact_decode
  import smbus_xact_pkg::*;
(
  input  logic [2:0]        proto_i,
  input  logic              rd_i,
  input  logic [STEP_W-1:0] step_i,
  output step_t             step_o
);
  step_t fin;
  assign fin = mk(OP_STOP, WS_NONE, RS_NONE, 1'b1, RES_INTR);

  always_comb begin
    step_o = fin;
    case (proto_i)
      PROTO_QUICK:
        if (step_i == 0) step_o = mk(OP_START, WS_ADDR_RAW, RS_NONE, 1'b0, RES_INTR);
      PROTO_BYTE:
        case (step_i)
          0: step_o = mk(OP_START, WS_ADDR_RAW, RS_NONE, 1'b0, RES_INTR);
          1: step_o = rd_i ? mk(OP_RECV_LAST, WS_NONE, RS_D0, 1'b0, RES_INTR)
                           : mk(OP_SEND, WS_CMD, RS_NONE, 1'b0, RES_INTR);
          default: step_o = fin;
        endcase
      PROTO_BDATA:
        case (step_i)
          0: step_o = mk(OP_START, WS_ADDR_WR, RS_NONE, 1'b0, RES_INTR);
          1: step_o = mk(OP_SEND, WS_CMD, RS_NONE, 1'b0, RES_INTR);
          2: step_o = rd_i ? mk(OP_RSTART, WS_ADDR_RD, RS_NONE, 1'b0, RES_INTR)
                           : mk(OP_SEND, WS_D0, RS_NONE, 1'b0, RES_INTR);
          3: if (rd_i) step_o = mk(OP_RECV_LAST, WS_NONE, RS_D0, 1'b0, RES_INTR);
          default: step_o = fin;
        endcase
      PROTO_WORD:
        case (step_i)
          0: step_o = mk(OP_START, WS_ADDR_WR, RS_NONE, 1'b0, RES_INTR);
          1: step_o = mk(OP_SEND, WS_CMD, RS_NONE, 1'b0, RES_INTR);
          2: step_o = rd_i ? mk(OP_RSTART, WS_ADDR_RD, RS_NONE, 1'b0, RES_INTR)
                           : mk(OP_SEND, WS_D0, RS_NONE, 1'b0, RES_INTR);
          3: step_o = rd_i ? mk(OP_RECV, WS_NONE, RS_D0, 1'b0, RES_INTR)
                           : mk(OP_SEND, WS_D1, RS_NONE, 1'b0, RES_INTR);
          4: if (rd_i) step_o = mk(OP_RECV_LAST, WS_NONE, RS_D1, 1'b0, RES_INTR);
          default: step_o = fin;
        endcase
      PROTO_BLOCK:
        case (step_i)
          0: step_o = mk(OP_START, WS_ADDR_WR, RS_NONE, 1'b0, RES_BYTE_DONE);
          1: step_o = mk(OP_SEND, WS_CMD, RS_NONE, 1'b0, RES_BYTE_DONE);
          2: step_o = rd_i ? mk(OP_RSTART, WS_ADDR_RD, RS_NONE, 1'b0, RES_BYTE_DONE)
                           : mk(OP_SEND, WS_D0, RS_NONE, 1'b1, RES_BYTE_DONE);
          default: step_o = mk(OP_RECV, WS_NONE, RS_D0, 1'b1, RES_BYTE_DONE);
        endcase
      PROTO_I2CRD:  // R/W bit deliberately unused
        case (step_i)
          0: step_o = mk(OP_START, WS_ADDR_WR, RS_NONE, 1'b0, RES_BYTE_DONE);
          1: step_o = mk(OP_SEND, WS_D1, RS_NONE, 1'b0, RES_BYTE_DONE);
          2: step_o = mk(OP_RSTART, WS_ADDR_RD, RS_NONE, 1'b0, RES_BYTE_DONE);
          default: step_o = mk(OP_RECV, WS_NONE, RS_D0, 1'b1, RES_BYTE_DONE);
        endcase
      default: step_o = fin;
    endcase
  end
endmodule

// File: rtl/smbus_xact_ctrl.sv
module smbus_xact_ctrl
  import smbus_xact_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              unsup_i,
  input  logic              ack_i,
  input  logic              nack_i,
  input  logic              last_i,
  input  res_e              res_i,
  input  logic              op_stop_i,
  output logic              req_o,
  output logic              abort_o,
  output logic              launch_o,
  output logic              capture_o,
  output logic [STEP_W-1:0] step_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              intr_o,
  output logic              bd_o,
  output logic              err_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_ABORT} state_e;
  state_e state_q;

  assign req_o     = (state_q != ST_IDLE);
  assign abort_o   = (state_q == ST_ABORT);
  assign launch_o  = start_i && (state_q == ST_IDLE);
  assign capture_o = (state_q == ST_RUN) && ack_i && !nack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_o  <= '0;
      done_o  <= 1'b0;
      busy_o  <= 1'b0;
      intr_o  <= 1'b0;
      bd_o    <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE:
          if (start_i) begin
            intr_o <= 1'b0;
            bd_o   <= 1'b0;
            step_o <= '0;
            if (unsup_i) begin
              busy_o <= 1'b0;
              err_o  <= 1'b1;
              done_o <= 1'b1;
            end else begin
              err_o   <= 1'b0;
              busy_o  <= 1'b1;
              state_q <= ST_RUN;
            end
          end
        ST_RUN:
          if (ack_i) begin
            if (nack_i && !op_stop_i) begin
              state_q <= ST_ABORT;
            end else if (nack_i) begin
              state_q <= ST_IDLE;
              busy_o  <= 1'b0;
              err_o   <= 1'b1;
              done_o  <= 1'b1;
            end else if (last_i) begin
              state_q <= ST_IDLE;
              done_o  <= 1'b1;
              if (res_i == RES_INTR) begin
                intr_o <= 1'b1;
                busy_o <= 1'b0;
              end else begin
                bd_o <= 1'b1;
              end
            end else begin
              step_o <= step_o + {{(STEP_W-1){1'b0}}, 1'b1};
            end
          end
        default:
          if (ack_i) begin
            state_q <= ST_IDLE;
            busy_o  <= 1'b0;
            err_o   <= 1'b1;
            done_o  <= 1'b1;
          end
      endcase
    end
  end
endmodule

// File: rtl/smbus_xact_seq.sv
module smbus_xact_seq
  import smbus_xact_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        proto_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] cmd_i,
  input  logic [DATA_W-1:0] data0_i,
  input  logic [DATA_W-1:0] data1_i,
  output logic              eng_req_o,
  output logic [2:0]        eng_op_o,
  output logic [DATA_W-1:0] eng_wdata_o,
  input  logic              eng_ack_i,
  input  logic              eng_nack_i,
  input  logic [DATA_W-1:0] eng_rdata_i,
  output logic              done_o,
  output logic              sts_busy_o,
  output logic              sts_intr_o,
  output logic              sts_byte_done_o,
  output logic              sts_dev_err_o,
  output logic [DATA_W-1:0] data0_o,
  output logic [DATA_W-1:0] data1_o
);
  logic              launch, capture, abort;
  logic [STEP_W-1:0] step_idx;
  step_t             cur;
  logic [2:0]        proto_q;
  logic [DATA_W-1:0] addr_q, cmd_q, d0_q, d1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      proto_q <= '0;
      addr_q  <= '0;
      cmd_q   <= '0;
      d0_q    <= '0;
      d1_q    <= '0;
    end else if (launch) begin
      proto_q <= proto_i;
      addr_q  <= addr_i;
      cmd_q   <= cmd_i;
      d0_q    <= data0_i;
      d1_q    <= data1_i;
    end else if (capture) begin
      if (cur.rsel == RS_D0) d0_q <= eng_rdata_i;
      if (cur.rsel == RS_D1) d1_q <= eng_rdata_i;
    end
  end

  smbus_xact_decode u_dec (
    .proto_i (proto_q),
    .rd_i    (addr_q[0]),
    .step_i  (step_idx),
    .step_o  (cur)
  );

  smbus_xact_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .unsup_i   (proto_unsup(proto_i)),
    .ack_i     (eng_ack_i),
    .nack_i    (eng_nack_i),
    .last_i    (cur.last),
    .res_i     (cur.res),
    .op_stop_i (abort || (cur.op == OP_STOP)),
    .req_o     (eng_req_o),
    .abort_o   (abort),
    .launch_o  (launch),
    .capture_o (capture),
    .step_o    (step_idx),
    .done_o    (done_o),
    .busy_o    (sts_busy_o),
    .intr_o    (sts_intr_o),
    .bd_o      (sts_byte_done_o),
    .err_o     (sts_dev_err_o)
  );

  assign eng_op_o = abort ? OP_STOP : cur.op;

  always_comb begin
    eng_wdata_o = '0;
    if (!abort) begin
      case (cur.wsel)
        WS_ADDR_RAW: eng_wdata_o = addr_q;
        WS_ADDR_WR:  eng_wdata_o = {addr_q[DATA_W-1:1], 1'b0};
        WS_ADDR_RD:  eng_wdata_o = {addr_q[DATA_W-1:1], 1'b1};
        WS_CMD:      eng_wdata_o = cmd_q;
        WS_D0:       eng_wdata_o = d0_q;
        WS_D1:       eng_wdata_o = d1_q;
        default:     eng_wdata_o = '0;
      endcase
    end
  end

  assign data0_o = d0_q;
  assign data1_o = d1_q;
endmodule

// File: rtl/smbus_xact_seq_chk.sv
module smbus_xact_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [2:0]        proto_i,
  input logic              eng_req_o,
  input logic [2:0]        eng_op_o,
  input logic [DATA_W-1:0] eng_wdata_o,
  input logic              eng_ack_i,
  input logic              eng_nack_i,
  input logic              done_o,
  input logic              sts_busy_o,
  input logic              sts_intr_o,
  input logic              sts_byte_done_o,
  input logic              sts_dev_err_o
);
  p_req_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && !eng_ack_i |=> eng_req_o && $stable(eng_op_o) && $stable(eng_wdata_o));

  p_first_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eng_req_o) |-> eng_op_o == 3'd0);

  p_bd_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_byte_done_o |-> sts_busy_o);

  p_stop_after_nack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && eng_ack_i && eng_nack_i && eng_op_o != 3'd5 |=> eng_req_o && eng_op_o == 3'd5);

  p_unsup_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !eng_req_o && (proto_i == 3'd4 || proto_i == 3'd7)
    |=> done_o && sts_dev_err_o && !eng_req_o);

  p_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o |-> sts_busy_o);

  p_one_result_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones({sts_intr_o, sts_byte_done_o, sts_dev_err_o}) == 1 && !eng_req_o);
endmodule

bind smbus_xact_seq smbus_xact_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .start_i         (start_i),
  .proto_i         (proto_i),
  .eng_req_o       (eng_req_o),
  .eng_op_o        (eng_op_o),
  .eng_wdata_o     (eng_wdata_o),
  .eng_ack_i       (eng_ack_i),
  .eng_nack_i      (eng_nack_i),
  .done_o          (done_o),
  .sts_busy_o      (sts_busy_o),
  .sts_intr_o      (sts_intr_o),
  .sts_byte_done_o (sts_byte_done_o),
  .sts_dev_err_o   (sts_dev_err_o)
);

// File: tb/smbus_xact_seq_bench.sv
`timescale 1ns/1ps
module smbus_xact_seq_bench;
  localparam int LAT = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] proto = '0;
  logic [7:0] addr = '0, cmd = '0, d0 = '0, d1 = '0;
  logic       eng_req;
  logic [2:0] eng_op;
  logic [7:0] eng_wdata;
  logic       eng_ack = 1'b0, eng_nack = 1'b0;
  logic [7:0] eng_rdata = '0;
  logic       done, busy, intr, bd, err;
  logic [7:0] q0, q1;

  int checks = 0, errors = 0;
  logic [2:0] exp_op[$];
  logic [7:0] exp_wd[$];
  int    nack_at = -1, op_idx = 0;
  logic [7:0] rd_seed = '0;
  string cur_tag = "";

  always #5 clk = ~clk;

  smbus_xact_seq u_smbus_xact_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .proto_i(proto),
    .addr_i(addr), .cmd_i(cmd), .data0_i(d0), .data1_i(d1),
    .eng_req_o(eng_req), .eng_op_o(eng_op), .eng_wdata_o(eng_wdata),
    .eng_ack_i(eng_ack), .eng_nack_i(eng_nack), .eng_rdata_i(eng_rdata),
    .done_o(done), .sts_busy_o(busy), .sts_intr_o(intr),
    .sts_byte_done_o(bd), .sts_dev_err_o(err), .data0_o(q0), .data1_o(q1)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", cur_tag, what, act, exp);
    end
  endtask

  // monitor: bit-engine model popping the expected operation queue
  initial begin
    forever begin
      @(negedge clk);
      if (eng_req && !eng_ack) begin
        repeat (LAT - 1) @(negedge clk);
        if (exp_op.size() == 0) begin
          chk("R1 unexpected op", eng_op, 7);
        end else begin
          logic [2:0] eo;
          logic [7:0] ew;
          eo = exp_op.pop_front();
          ew = exp_wd.pop_front();
          chk("R1 op", eng_op, eo);
          if (eo == 3'd0 || eo == 3'd1 || eo == 3'd4) chk("R1 wdata", eng_wdata, ew);
        end
        eng_ack  = 1'b1;
        eng_nack = (op_idx == nack_at);
        if (eng_op == 3'd2 || eng_op == 3'd3) begin
          eng_rdata = rd_seed;
          rd_seed   = rd_seed + 8'd1;
        end
        op_idx++;
        @(negedge clk);
        eng_ack  = 1'b0;
        eng_nack = 1'b0;
      end
    end
  end

  // driver: expected sequence from the requirements, then a start pulse
  task automatic run(input string tag, input logic [2:0] p, input logic [7:0] a, c, x0, x1,
                     input logic [7:0] seed, input int nk, input bit poke,
                     input logic [2:0] exp_res, input bit exp_busy,
                     input logic [7:0] e0, e1);
    logic [2:0] lop[$];
    logic [7:0] lwd[$];
    logic [7:0] aw, ar;
    int w;
    aw = {a[7:1], 1'b0};
    ar = {a[7:1], 1'b1};
    case (p)
      3'd0: begin lop = '{0, 5}; lwd = '{a, 0}; end
      3'd1: if (a[0]) begin lop = '{0, 3, 5}; lwd = '{a, 0, 0}; end
            else      begin lop = '{0, 1, 5}; lwd = '{a, c, 0}; end
      3'd2: if (a[0]) begin lop = '{0, 1, 4, 3, 5}; lwd = '{aw, c, ar, 0, 0}; end
            else      begin lop = '{0, 1, 1, 5};    lwd = '{aw, c, x0, 0}; end
      3'd3: if (a[0]) begin lop = '{0, 1, 4, 2, 3, 5}; lwd = '{aw, c, ar, 0, 0, 0}; end
            else      begin lop = '{0, 1, 1, 1, 5};    lwd = '{aw, c, x0, x1, 0}; end
      3'd5: if (a[0]) begin lop = '{0, 1, 4, 2}; lwd = '{aw, c, ar, 0}; end
            else      begin lop = '{0, 1, 1};    lwd = '{aw, c, x0}; end
      3'd6: begin lop = '{0, 1, 4, 2}; lwd = '{aw, x1, ar, 0}; end
      default: begin lop = {}; lwd = {}; end
    endcase
    if (nk >= 0 && nk < lop.size()) begin
      for (int i = lop.size() - 1; i > nk; i--) begin
        void'(lop.pop_back());
        void'(lwd.pop_back());
      end
      if (lop[nk] != 3'd5) begin lop.push_back(3'd5); lwd.push_back(8'd0); end
    end
    exp_op = lop; exp_wd = lwd;
    op_idx = 0; nack_at = nk; rd_seed = seed; cur_tag = tag;
    @(negedge clk);
    proto = p; addr = a; cmd = c; d0 = x0; d1 = x1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      @(negedge clk);
      proto = 3'd0; addr = 8'hEE; d0 = 8'h77; d1 = 8'h66; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (!done && w < 200) begin @(negedge clk); w++; end
    chk("R11 done pulse", done, 1);
    chk("result {err,bd,intr}", {err, bd, intr}, exp_res);
    chk("busy", busy, exp_busy);
    chk("data0", q0, e0);
    chk("data1", q1, e1);
    chk("R1 ops left", exp_op.size(), 0);
    @(negedge clk);
    chk("R11 done one cycle", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R11 actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_tag = "R11 reset";
    chk("outputs", {eng_req, done, busy, intr, bd, err}, 0);
    chk("data", {q0, q1}, 0);
    rst_n = 1'b1;
    run("R2 quick write", 3'd0, 8'h50, 8'h00, 8'h01, 8'h02, 8'h00, -1, 0, 3'b001, 0, 8'h01, 8'h02);
    run("R2 quick read",  3'd0, 8'h51, 8'h00, 8'h03, 8'h04, 8'h00, -1, 0, 3'b001, 0, 8'h03, 8'h04);
    run("R3 byte write",  3'd1, 8'h5A, 8'h3C, 8'h05, 8'h06, 8'h00, -1, 0, 3'b001, 0, 8'h05, 8'h06);
    run("R3 byte read",   3'd1, 8'h5B, 8'h00, 8'h07, 8'h08, 8'h11, -1, 0, 3'b001, 0, 8'h11, 8'h08);
    run("R4 bdata write", 3'd2, 8'h34, 8'h07, 8'h99, 8'h09, 8'h00, -1, 0, 3'b001, 0, 8'h99, 8'h09);
    run("R4 bdata read",  3'd2, 8'h35, 8'h08, 8'h0A, 8'h0B, 8'h22, -1, 0, 3'b001, 0, 8'h22, 8'h0B);
    run("R5 word write",  3'd3, 8'h48, 8'h09, 8'h12, 8'h34, 8'h00, -1, 0, 3'b001, 0, 8'h12, 8'h34);
    run("R5 word read",   3'd3, 8'h49, 8'h0A, 8'h00, 8'h00, 8'h40, -1, 0, 3'b001, 0, 8'h40, 8'h41);
    run("R6 block write", 3'd5, 8'h20, 8'h01, 8'h03, 8'h0C, 8'h00, -1, 0, 3'b010, 1, 8'h03, 8'h0C);
    run("R6 block read",  3'd5, 8'h21, 8'h02, 8'h00, 8'h0D, 8'h05, -1, 0, 3'b010, 1, 8'h05, 8'h0D);
    run("R7 i2c rd bit1", 3'd6, 8'hA1, 8'h00, 8'h00, 8'h10, 8'h33, -1, 0, 3'b010, 1, 8'h33, 8'h10);
    run("R7 i2c rd bit0", 3'd6, 8'hA0, 8'h00, 8'h00, 8'h20, 8'h44, -1, 0, 3'b010, 1, 8'h44, 8'h20);
    run("R8 nack addr",   3'd3, 8'h48, 8'h09, 8'h12, 8'h34, 8'h00,  0, 0, 3'b100, 0, 8'h12, 8'h34);
    run("R8 nack data",   3'd3, 8'h48, 8'h09, 8'h56, 8'h78, 8'h00,  2, 0, 3'b100, 0, 8'h56, 8'h78);
    run("R8 nack read",   3'd2, 8'h35, 8'h08, 8'h0E, 8'h0F, 8'h00,  2, 0, 3'b100, 0, 8'h0E, 8'h0F);
    run("R11 clear",      3'd0, 8'h50, 8'h00, 8'h01, 8'h02, 8'h00, -1, 0, 3'b001, 0, 8'h01, 8'h02);
    run("R9 code 4",      3'd4, 8'h50, 8'h00, 8'h1A, 8'h1B, 8'h00, -1, 0, 3'b100, 0, 8'h1A, 8'h1B);
    run("R9 code 7",      3'd7, 8'h50, 8'h00, 8'h1C, 8'h1D, 8'h00, -1, 0, 3'b100, 0, 8'h1C, 8'h1D);
    run("R10 mid start",  3'd3, 8'h49, 8'h0A, 8'h00, 8'h00, 8'h60, -1, 1, 3'b001, 0, 8'h60, 8'h61);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule